// File: doc/BRIEF.md
# Tuning Word Loader

The block takes in the 40-bit control frame of a numerically controlled oscillator and holds it until software decides it should take effect. A frame can arrive in either of two ways. It can come as five byte writes on an 8-bit bus, or as forty single bits on bit 0 of that bus. Each byte or bit is marked by a rising edge on an asynchronous load clock. A second asynchronous strobe, the commit strobe, copies the assembled input frame into the active register. The oscillator core reads only the active register, so the frame is double-buffered.

Both strobes pass through a two-flop synchronizer and a rising-edge detector in the core clock domain. A state machine tracks the write position. **EMPTY** means no write has arrived since reset or the last commit. **PAR** means parallel collection is in progress. **SER** means serial collection is in progress. **FULL** means the frame is complete and further writes are dropped. The named transitions are:

- *start_par*: EMPTY goes to PAR on a write while `serial_mode` is 0.
- *start_ser*: EMPTY goes to SER on a write while `serial_mode` is 1.
- *byte_done*: PAR goes to FULL on the fifth byte.
- *bit_done*: SER goes to FULL on the fortieth bit.
- *rewind*: any state goes to EMPTY on a commit.

The input register keeps its contents across a commit. After a partial load, a commit therefore transfers the newly written parts together with whatever the earlier frame left behind.

Top module: `tuneword_loader`

## Requirements
- R1: Reset clears the active register, so all outputs read 0, and sets the state to EMPTY. After reset, the first parallel write is taken as byte 1.
- R2: In parallel mode, the first byte sets the phase word from bits 7:3, the power-down flag from bit 2 and the control bits from bits 1:0.
- R3: In parallel mode, bytes 2, 3, 4 and 5 give tuning word bits 31:24, 23:16, 15:8 and 7:0 in that order.
- R4: In serial mode, forty bits are taken from `data_in[0]` with the least significant bit first. Frame bits 31:0 are the tuning word, bits 33:32 are the control bits, bit 34 is power-down and bits 39:35 are the phase word. `data_in[7:1]` is ignored.
- R5: Outputs change only in response to a commit strobe. Writes alone leave them unchanged. The active register takes the value the input register held in the cycle the commit was detected.
- R6: A commit returns the write position to the start, so the next write is byte 1 or bit 0.
- R7: Once five bytes or forty bits have been taken, further writes before a commit are ignored.
- R8: The mode is fixed by the value of `serial_mode` at the first write of a frame. A change of `serial_mode` later in the frame has no effect on that frame.
- R9: A commit that follows no new write commits the held frame again, and the outputs stay the same.
- R10: Each rising edge of a strobe acts exactly once, however long the strobe stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| serial_mode | input | 1 | 1 selects serial loading, sampled at the first write of a frame |
| data_in | input | 8 | Byte bus; serial mode uses bit 0 only |
| load_clk | input | 1 | Asynchronous write strobe; the rising edge takes one byte or bit |
| commit_in | input | 1 | Asynchronous commit strobe; the rising edge copies the frame to the outputs |
| tune_word | output | 32 | Active frequency tuning word |
| phase_word | output | 5 | Active phase word |
| pwr_down | output | 1 | Active power-down flag |
| ctrl_bits | output | 2 | Active control bits |

## Verification
The bench builds the block with its default parameters: a 32-bit tuning word, a 5-bit phase word, 2 control bits, an 8-bit bus and two synchronizer stages. With these values a whole frame is five bytes or forty bits, so both full sequences, the FULL boundary after the last element and the overrun write beyond it are reached in a short run. Frames with alternating and all-ones patterns expose any swapped byte order or reversed bit order. Mode flips in mid-frame, strobes held high for many cycles and a reset in mid-frame reach the remaining paths of the state machine.

// File: rtl/tl_pkg.sv
package tl_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_PAR   = 2'd1,
        ST_SER   = 2'd2,
        ST_FULL  = 2'd3
    } ld_state_t;
endpackage

// File: rtl/tl_edge_sync.sv
module tl_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_o
);
    // sh[STAGES-1:0] synchronize, sh[STAGES] holds the previous synced value
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-1:0], async_in};
    end

    assign rise_o = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/tl_frame_asm.sv
module tl_frame_asm
    import tl_pkg::*;
#(
    parameter int FRAME_W = 40,
    parameter int BYTE_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_pulse,
    input  logic               commit_pulse,
    input  logic               serial_mode,
    input  logic [BYTE_W-1:0]  data_in,
    output logic [FRAME_W-1:0] frame_o,
    output ld_state_t          state_o
);
    localparam int NUM_BYTES = FRAME_W / BYTE_W;
    localparam int CNT_W     = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] LAST_BYTE = CNT_W'(NUM_BYTES - 1);
    localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(FRAME_W - 1);

    ld_state_t          state, nstate;
    logic [CNT_W-1:0]   cnt, ncnt;
    logic               take_byte, take_bit;
    logic [FRAME_W-1:0] frame_q, frame_d;

    // next state and write position
    always_comb begin
        nstate    = state;
        ncnt      = cnt;
        take_byte = 1'b0;
        take_bit  = 1'b0;
        if (commit_pulse) begin
            nstate = ST_EMPTY;          // rewind
            ncnt   = '0;
        end else if (wr_pulse) begin
            unique case (state)
                ST_EMPTY: begin
                    ncnt = CNT_W'(1);
                    if (serial_mode) begin
                        take_bit = 1'b1;
                        nstate   = ST_SER;  // start_ser
                    end else begin
                        take_byte = 1'b1;
                        nstate    = ST_PAR; // start_par
                    end
                end
                ST_PAR: begin
                    take_byte = 1'b1;
                    ncnt      = cnt + 1'b1;
                    if (cnt == LAST_BYTE) nstate = ST_FULL; // byte_done
                end
                ST_SER: begin
                    take_bit = 1'b1;
                    ncnt     = cnt + 1'b1;
                    if (cnt == LAST_BIT) nstate = ST_FULL;  // bit_done
                end
                ST_FULL: begin
                    nstate = ST_FULL;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_EMPTY;
            cnt   <= '0;
        end else begin
            state <= nstate;
            cnt   <= ncnt;
        end
    end

    // input frame data path
    always_comb begin
        frame_d = frame_q;
        if (take_bit)
            frame_d = {data_in[0], frame_q[FRAME_W-1:1]};
        if (take_byte) begin
            for (int k = 0; k < NUM_BYTES; k++) begin
                if (cnt == CNT_W'(k))
                    frame_d[FRAME_W-1-BYTE_W*k -: BYTE_W] = data_in;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) frame_q <= '0;
        else        frame_q <= frame_d;
    end

    assign frame_o = frame_q;
    assign state_o = state;
endmodule

// File: rtl/tuneword_loader.sv
module tuneword_loader
    import tl_pkg::*;
#(
    parameter int TUNE_W      = 32,
    parameter int PHASE_W     = 5,
    parameter int CTRL_W      = 2,
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               serial_mode,
    input  logic [BYTE_W-1:0]  data_in,
    input  logic               load_clk,
    input  logic               commit_in,
    output logic [TUNE_W-1:0]  tune_word,
    output logic [PHASE_W-1:0] phase_word,
    output logic               pwr_down,
    output logic [CTRL_W-1:0]  ctrl_bits
);
    localparam int FRAME_W = TUNE_W + CTRL_W + 1 + PHASE_W;
    localparam int PD_BIT  = TUNE_W + CTRL_W;
    localparam int PH_LSB  = PD_BIT + 1;
    localparam int N_STRB  = 2;

    logic [N_STRB-1:0]  strobe_raw, strobe_rise;
    logic               wr_pulse, commit_pulse;
    logic [FRAME_W-1:0] frame_q, active_q;
    ld_state_t          asm_state;

    assign strobe_raw = {commit_in, load_clk};

    for (genvar g = 0; g < N_STRB; g++) begin : g_sync
        tl_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .async_in (strobe_raw[g]),
            .rise_o   (strobe_rise[g])
        );
    end

    assign wr_pulse     = strobe_rise[0];
    assign commit_pulse = strobe_rise[1];

    tl_frame_asm #(.FRAME_W(FRAME_W), .BYTE_W(BYTE_W)) u_asm (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_pulse     (wr_pulse),
        .commit_pulse (commit_pulse),
        .serial_mode  (serial_mode),
        .data_in      (data_in),
        .frame_o      (frame_q),
        .state_o      (asm_state)
    );

    // active register: the only state the core reads
    always_ff @(posedge clk) begin
        if (!rst_n)            active_q <= '0;
        else if (commit_pulse) active_q <= frame_q;
    end

    assign tune_word  = active_q[TUNE_W-1:0];
    assign ctrl_bits  = active_q[PD_BIT-1:TUNE_W];
    assign pwr_down   = active_q[PD_BIT];
    assign phase_word = active_q[FRAME_W-1:PH_LSB];
endmodule

// File: rtl/tuneword_loader_chk.sv
module tuneword_loader_chk
    import tl_pkg::*;
#(
    parameter int FRAME_W = 40
) (
    input logic               clk,
    input logic               rst_n,
    input logic               commit_pulse,
    input ld_state_t          state,
    input logic [FRAME_W-1:0] frame_q,
    input logic [FRAME_W-1:0] active_q
);
    // R5
    outputs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_pulse |=> $stable(active_q));

    // R5
    commit_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_pulse |=> active_q == $past(frame_q));

    // R6
    ptr_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_pulse |=> state == ST_EMPTY);

    // R7
    full_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_FULL |=> $stable(frame_q));

    // R7
    full_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FULL && !commit_pulse) |=> state == ST_FULL);

    // R8
    mode_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PAR && !commit_pulse) |=> (state == ST_PAR || state == ST_FULL));
endmodule

bind tuneword_loader tuneword_loader_chk #(.FRAME_W(FRAME_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .commit_pulse (commit_pulse),
    .state        (asm_state),
    .frame_q      (frame_q),
    .active_q     (active_q)
);

// File: tb/sim_tuneword_loader.sv
`timescale 1ns/1ps
module sim_tuneword_loader;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       serial_mode = 1'b0;
    logic [7:0] data_in = '0;
    logic       load_clk = 1'b0;
    logic       commit_in = 1'b0;
    logic [31:0] tune_word;
    logic [4:0]  phase_word;
    logic        pwr_down;
    logic [1:0]  ctrl_bits;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tuneword_loader u0 (
        .clk(clk), .rst_n(rst_n), .serial_mode(serial_mode), .data_in(data_in),
        .load_clk(load_clk), .commit_in(commit_in), .tune_word(tune_word),
        .phase_word(phase_word), .pwr_down(pwr_down), .ctrl_bits(ctrl_bits)
    );

    // bit 40 = serial mode, bits 39:0 = frame
    localparam logic [40:0] VEC [0:5] = '{
        {1'b0, 40'hA5_DEADBEEF},
        {1'b1, 40'h5A_01234567},
        {1'b0, 40'hFF_FFFFFFFF},
        {1'b1, 40'h00_00000001},
        {1'b1, 40'hC3_80000000},
        {1'b0, 40'h81_7FFFFFFE}
    };

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic chk_frame(input string tag, input logic [39:0] f);
        chk(tag, "tune",  tune_word,         f[31:0]);
        chk(tag, "ctrl",  32'(ctrl_bits),    32'(f[33:32]));
        chk(tag, "pd",    32'(pwr_down),     32'(f[34]));
        chk(tag, "phase", 32'(phase_word),   32'(f[39:35]));
    endtask

    task automatic send_word(input logic [7:0] d, input int hold);
        @(negedge clk);
        data_in  = d;
        load_clk = 1'b1;
        repeat (hold) @(negedge clk);
        load_clk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic commit(input int hold);
        @(negedge clk);
        commit_in = 1'b1;
        repeat (hold) @(negedge clk);
        commit_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic send_byte_k(input logic [39:0] f, input int k, input int hold);
        send_word(f[39-8*k -: 8], hold);
    endtask

    task automatic load_frame(input logic mode, input logic [39:0] f, input int hold);
        serial_mode = mode;
        if (mode) begin
            for (int i = 0; i < 40; i++) send_word({7'b1010101, f[i]}, hold);
        end else begin
            for (int k = 0; k < 5; k++) send_byte_k(f, k, hold);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [39:0] fa, fb;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1 reset state
        chk_frame("R1", 40'h0);

        // table walk: R2/R3 parallel, R4 serial
        for (int v = 0; v < 6; v++) begin
            load_frame(VEC[v][40], VEC[v][39:0], 1);
            commit(1);
            if (VEC[v][40]) chk_frame("R4", VEC[v][39:0]);
            else begin
                chk("R3", "tune", tune_word, VEC[v][31:0]);
                chk("R2", "byte1", {27'b0, phase_word, pwr_down, ctrl_bits}, 32'(VEC[v][39:32]));
            end
        end

        // R5: writes without commit leave outputs alone
        fa = 40'h3C_11223344;
        load_frame(1'b0, fa, 1);
        chk_frame("R5", VEC[5][39:0]);
        // R7: sixth byte ignored
        send_word(8'hFF, 1);
        commit(1);
        chk_frame("R7", fa);

        // R9: repeated commit keeps outputs
        commit(1);
        chk_frame("R9", fa);

        // R6: partial load, commit, then a full frame starts at byte 1
        serial_mode = 1'b0;
        send_word(8'h11, 1);
        send_word(8'h22, 1);
        commit(1);
        fb = 40'h6B_CAFEF00D;
        load_frame(1'b0, fb, 1);
        commit(1);
        chk_frame("R6", fb);

        // R8: mode flip in mid parallel frame
        fa = 40'h97_0F0F0F0F;
        serial_mode = 1'b0;
        send_byte_k(fa, 0, 1);
        serial_mode = 1'b1;
        for (int k = 1; k < 5; k++) send_byte_k(fa, k, 1);
        commit(1);
        chk_frame("R8", fa);

        // R8: mode flip in mid serial frame
        fb = 40'h2E_A5A5A5A5;
        serial_mode = 1'b1;
        send_word({7'b0, fb[0]}, 1);
        serial_mode = 1'b0;
        for (int i = 1; i < 40; i++) send_word({7'b0, fb[i]}, 1);
        commit(1);
        chk_frame("R8", fb);

        // R7: forty-first serial bit ignored
        fa = 40'h4D_13579BDF;
        load_frame(1'b1, fa, 1);
        send_word(8'hFF, 1);
        commit(1);
        chk_frame("R7", fa);

        // R10: strobes held high for many cycles act once
        fb = 40'hB2_2468ACE0;
        load_frame(1'b0, fb, 9);
        commit(12);
        chk_frame("R10", fb);

        // R1: reset in mid frame clears outputs and write position
        serial_mode = 1'b0;
        send_word(8'h77, 1);
        send_word(8'h88, 1);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk_frame("R1", 40'h0);
        fa = 40'h59_DEC0DE01;
        load_frame(1'b0, fa, 1);
        commit(1);
        chk_frame("R1", fa);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule